// File: doc/BRIEF.md
# Pounds-Ounces Weighing Counter

This block counts the pulses that a dual-slope converter emits during a conversion and shows the result in engineering units for a weighing display. Each pulse adds one ounce. A binary ounce field runs from 0 to 15. Each time it wraps it advances a whole-pound field of two decimal digits. When the counter has passed through its whole range of 100 pounds by 16 ounces, which is 1600 pulses, and returns to zero, it raises a carry back to the converter. The converter uses that carry to end input integration and to sense overrange.

When conversion ends, the block freezes the reading into a display register. The converter's overrange flag becomes the leading half digit of the pounds, which takes the reading up to 199 lb 15 oz. The binary ounce count becomes two BCD digits. The counter-reset pulse clears the counting stages at the start of every conversion. The display keeps the previous reading until the next end-of-conversion strobe.

Top module: `lbo_weigh_counter`

## Requirements
- R1: After reset, every display output and `carry_o` are 0.
- R2: Each clock cycle with `pulse_i` high adds one ounce. The ounce count runs 0..15 in binary, and the pulse that takes 15 ounces to 0 also adds one pound.
- R3: The pounds are two BCD digits, 00 to 99, with the units digit in `lb_bcd_o[3:0]` and the tens digit in `lb_bcd_o[7:4]`. Neither digit ever exceeds 9.
- R4: The pulse that takes 99 lb 15 oz to 00 lb 0 oz drives `carry_o` high for exactly the next cycle. `carry_o` is high at no other time, so it rises once in every 1600 pulses.
- R5: `clear_i` sets the counting stages to zero at the clock edge and wins over a pulse in the same cycle. It also drops `carry_o`, and it does not change the display.
- R6: The display outputs change only at a clock edge where `eoc_i` is high. At that edge they capture the count as it stood before any pulse in the same cycle.
- R7: The ounce reading is shown as two BCD digits. `oz_tens_o` is 0 or 1 and `oz_units_o` is 0 to 9, for example 11 oz gives 1 and 1.
- R8: At an `eoc_i` edge, `hund_o` takes the value of `ovr_i`, forming the hundreds half digit of the pounds.
- R9: Cycles with `pulse_i` low leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Count strobe, one ounce per high cycle |
| clear_i | input | 1 | Synchronous clear of the counting stages |
| eoc_i | input | 1 | End-of-conversion strobe that loads the display |
| ovr_i | input | 1 | Overrange flag from the converter |
| hund_o | output | 1 | Latched hundreds half digit of pounds |
| lb_bcd_o | output | 8 | Latched pounds, two BCD digits |
| oz_tens_o | output | 4 | Latched ounce tens digit (0 or 1) |
| oz_units_o | output | 4 | Latched ounce units digit |
| carry_o | output | 1 | Full-scale carry back to the converter |

## Verification
The bench builds the block with its default parameters: a 4-bit ounce field and two pound digits. With these values the full 1600-pulse cycle fits in a few thousand clocks, so the bench can drive the exact wrap from 99:15 to 00:00 and watch the single carry cycle. The same values also bring within reach a mid-range reading with an ounce tens digit of 1 together with the overrange half digit, and a clear that arrives in the same cycle as a pulse.

// File: rtl/lbo_pkg.sv
package lbo_pkg;

  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // Next state of one decade stage.
  function automatic bcd_t dec_next(input bcd_t d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // Shift-and-add-3 conversion of a value below 100 into {tens, units}.
  function automatic logic [7:0] bin_to_bcd8(input logic [7:0] v);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = 4'd0;
    units = 4'd0;
    for (int i = 7; i >= 0; i--) begin
      if (units >= 4'd5) units = units + 4'd3;
      if (tens  >= 4'd5) tens  = tens  + 4'd3;
      tens  = {tens[2:0], units[3]};
      units = {units[2:0], v[i]};
    end
    return {tens, units};
  endfunction

  // True when every 4-bit digit in a packed field is a legal BCD value.
  function automatic logic digits_ok(input logic [31:0] f, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < n && f[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/lbo_oz_ctr.sv
module lbo_oz_ctr #(
  parameter int OZ_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               step_i,
  output logic [OZ_BITS-1:0] val_o,
  output logic               roll_o
);
  localparam logic [OZ_BITS-1:0] OZ_MAX = {OZ_BITS{1'b1}};

  logic [OZ_BITS-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign val_o  = cnt_q;
  assign roll_o = step_i && (cnt_q == OZ_MAX);
endmodule

// File: rtl/lbo_dec_ctr.sv
module lbo_dec_ctr
  import lbo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output bcd_t dig_o,
  output logic roll_o
);
  bcd_t dig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dig_q <= '0;
    else if (clr_i)  dig_q <= '0;
    else if (step_i) dig_q <= dec_next(dig_q);
  end

  assign dig_o  = dig_q;
  assign roll_o = step_i && (dig_q == 4'd9);
endmodule

// File: rtl/lbo_disp_latch.sv
module lbo_disp_latch
  import lbo_pkg::*;
#(
  parameter int OZ_BITS   = 4,
  parameter int LB_DIGITS = 2,
  localparam int LB_W     = LB_DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               ovr_i,
  input  logic [OZ_BITS-1:0] oz_i,
  input  logic [LB_W-1:0]    lb_i,
  output logic               hund_o,
  output logic [LB_W-1:0]    lb_o,
  output bcd_t               oz_tens_o,
  output bcd_t               oz_units_o
);
  logic [7:0] oz_bcd;

  assign oz_bcd = bin_to_bcd8(8'(oz_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hund_o     <= 1'b0;
      lb_o       <= '0;
      oz_tens_o  <= '0;
      oz_units_o <= '0;
    end else if (load_i) begin
      hund_o     <= ovr_i;
      lb_o       <= lb_i;
      oz_tens_o  <= oz_bcd[7:4];
      oz_units_o <= oz_bcd[3:0];
    end
  end
endmodule

// File: rtl/lbo_weigh_counter.sv
module lbo_weigh_counter
  import lbo_pkg::*;
#(
  parameter int OZ_BITS   = 4,
  parameter int LB_DIGITS = 2,
  localparam int LB_W     = LB_DIGITS * DIGIT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse_i,
  input  logic            clear_i,
  input  logic            eoc_i,
  input  logic            ovr_i,
  output logic            hund_o,
  output logic [LB_W-1:0] lb_bcd_o,
  output logic [3:0]      oz_tens_o,
  output logic [3:0]      oz_units_o,
  output logic            carry_o
);
  logic [OZ_BITS-1:0] oz_val;
  logic [LB_DIGITS:0] roll_chain;
  logic [LB_W-1:0]    lb_val;
  logic               wrap_evt;
  logic               latch_evt;
  logic               carry_q;

  lbo_oz_ctr #(.OZ_BITS(OZ_BITS)) oz_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clear_i),
    .step_i (pulse_i),
    .val_o  (oz_val),
    .roll_o (roll_chain[0])
  );

  for (genvar g = 0; g < LB_DIGITS; g++) begin : g_lb
    lbo_dec_ctr dec_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .step_i (roll_chain[g]),
      .dig_o  (lb_val[g*DIGIT_W +: DIGIT_W]),
      .roll_o (roll_chain[g+1])
    );
  end

  assign wrap_evt  = roll_chain[LB_DIGITS];
  assign latch_evt = eoc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= wrap_evt && !clear_i;
  end
  assign carry_o = carry_q;

  lbo_disp_latch #(.OZ_BITS(OZ_BITS), .LB_DIGITS(LB_DIGITS)) disp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (latch_evt),
    .ovr_i      (ovr_i),
    .oz_i       (oz_val),
    .lb_i       (lb_val),
    .hund_o     (hund_o),
    .lb_o       (lb_bcd_o),
    .oz_tens_o  (oz_tens_o),
    .oz_units_o (oz_units_o)
  );
endmodule

// File: rtl/lbo_weigh_chk.sv
module lbo_weigh_chk
  import lbo_pkg::*;
#(
  parameter int LB_DIGITS = 2,
  localparam int LB_W     = LB_DIGITS * DIGIT_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pulse_i,
  input logic            clear_i,
  input logic            eoc_i,
  input logic            ovr_i,
  input logic            hund_o,
  input logic [LB_W-1:0] lb_bcd_o,
  input logic [3:0]      oz_tens_o,
  input logic [3:0]      oz_units_o,
  input logic            carry_o,
  input logic            wrap_evt
);
  // R4
  carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  // R4
  carry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> ($past(pulse_i) && !$past(clear_i)));

  // R4
  wrap_to_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !clear_i) |=> carry_o);

  // R5
  clear_drops_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !carry_o);

  // R6
  display_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_i |=> $stable({hund_o, lb_bcd_o, oz_tens_o, oz_units_o}));

  // R8
  half_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_i |=> (hund_o == $past(ovr_i)));

  // R7
  oz_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oz_tens_o <= 4'd1) && (oz_units_o <= 4'd9));

  // R3
  lb_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(32'(lb_bcd_o), LB_DIGITS));
endmodule

bind lbo_weigh_counter lbo_weigh_chk #(.LB_DIGITS(LB_DIGITS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulse_i    (pulse_i),
  .clear_i    (clear_i),
  .eoc_i      (eoc_i),
  .ovr_i      (ovr_i),
  .hund_o     (hund_o),
  .lb_bcd_o   (lb_bcd_o),
  .oz_tens_o  (oz_tens_o),
  .oz_units_o (oz_units_o),
  .carry_o    (carry_o),
  .wrap_evt   (wrap_evt)
);

// File: tb/lbo_weigh_counter_tb_top.sv
module lbo_weigh_counter_tb_top;
  localparam int OZ_PER_LB = 16;
  localparam int FULL      = 1600;
  localparam int EXP_W     = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pulse_i = 1'b0;
  logic       clear_i = 1'b0;
  logic       eoc_i = 1'b0;
  logic       ovr_i = 1'b0;
  logic       hund_o;
  logic [7:0] lb_bcd_o;
  logic [3:0] oz_tens_o;
  logic [3:0] oz_units_o;
  logic       carry_o;

  int n_checks = 0;
  int n_errors = 0;
  int model_n  = 0;
  bit done     = 1'b0;
  logic [EXP_W-1:0] exp_q[$];
  logic [EXP_W-1:0] last_exp = '0;

  always #2.5 clk = ~clk;

  lbo_weigh_counter dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .clear_i(clear_i),
    .eoc_i(eoc_i), .ovr_i(ovr_i), .hund_o(hund_o), .lb_bcd_o(lb_bcd_o),
    .oz_tens_o(oz_tens_o), .oz_units_o(oz_units_o), .carry_o(carry_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [EXP_W-1:0] expect_of(input int n, input logic ovr);
    int lb, oz;
    logic [3:0] ozt, ozu;
    lb  = n / OZ_PER_LB;
    oz  = n - lb * OZ_PER_LB;
    ozt = (oz >= 10) ? 4'd1 : 4'd0;
    ozu = 4'(oz - ((oz >= 10) ? 10 : 0));
    return {ovr, 4'(lb / 10), 4'(lb % 10), ozt, ozu};
  endfunction

  function automatic logic [EXP_W-1:0] observed();
    return {hund_o, lb_bcd_o, oz_tens_o, oz_units_o};
  endfunction

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      pulse_i = 1'b1;
      @(negedge clk);
      model_n = (model_n + 1) % FULL;
    end
    pulse_i = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Driver: pushes the expected display then strobes end of conversion.
  task automatic conv_end(input logic ovr);
    logic [EXP_W-1:0] e;
    e = expect_of(model_n, ovr);
    exp_q.push_back(e);
    last_exp = e;
    ovr_i = ovr;
    eoc_i = 1'b1;
    @(negedge clk);
    eoc_i = 1'b0;
    ovr_i = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares the display after every end-of-conversion edge (R6, R7, R8).
  initial begin
    forever begin
      @(posedge clk);
      if (eoc_i) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected load", int'(observed()), 0);
        end else begin
          logic [EXP_W-1:0] e;
          e = exp_q.pop_front();
          check(observed() == e, "R2/R3/R6/R7/R8 display", int'(observed()), int'(e));
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    check(observed() == '0, "R1 display", int'(observed()), 0);
    check(carry_o == 1'b0, "R1 carry", int'(carry_o), 0);
    rst_n = 1'b1;
    idle(2);
    check(observed() == '0, "R1 display after release", int'(observed()), 0);

    // R2 R7: five ounces
    pulses(5);
    conv_end(1'b0);

    // R9: idle cycles leave the count
    idle(10);
    conv_end(1'b0);

    // R3 R7 R8: 12 lb 11 oz with the half digit set
    pulses(12 * 16 + 11 - 5);
    conv_end(1'b1);

    // R6: display holds while counting with no strobe
    pulses(7);
    idle(3);
    check(observed() == last_exp, "R6 hold", int'(observed()), int'(last_exp));

    // R5: clear together with a pulse, display unchanged
    clear_i = 1'b1;
    pulse_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    pulse_i = 1'b0;
    model_n = 0;
    check(observed() == last_exp, "R5 display kept", int'(observed()), int'(last_exp));
    conv_end(1'b0);

    // R4: full-scale wrap
    pulses(FULL - 1);
    check(carry_o == 1'b0, "R4 no carry before wrap", int'(carry_o), 0);
    conv_end(1'b0);
    pulses(1);
    check(carry_o == 1'b1, "R4 carry on wrap", int'(carry_o), 1);
    @(negedge clk);
    check(carry_o == 1'b0, "R4 carry one cycle", int'(carry_o), 0);
    conv_end(1'b1);

    // R2 R3: 2 lb 5 oz after wrap
    pulses(37);
    conv_end(1'b0);

    // R5: clear on the wrapping pulse suppresses carry
    pulses(FULL - 37 - 1);
    clear_i = 1'b1;
    pulse_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    pulse_i = 1'b0;
    model_n = 0;
    check(carry_o == 1'b0, "R5 clear beats carry", int'(carry_o), 0);
    pulses(1);
    conv_end(1'b0);

    idle(3);
    check(exp_q.size() == 0, "R6 all loads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule